// File: doc/BRIEF.md
# Cascadable LCD Segment Column Driver

This block collects one display line of column data for a dot-matrix STN panel and turns every column into a two-bit code. The code selects one of four drive levels. Data arrives on a parallel bus that is either 8 or 4 bits wide, one chunk per rising edge of the shift clock. A bit-position counter steers each chunk into a 160-bit staging register, which is organised as twenty 8-bit groups. A direction input sets the fill order, either from the first column upward or from the last column downward.

A load strobe copies the staging register into the line register, which drives the outputs, and starts the next line at the first group. Two bidirectional chain pins pass an enable token between drivers, so several drivers can share one data bus. Each driver takes its share of the line in turn, and the direction input sets which pin receives the token. The level of each column follows from its latched bit and the AC-inversion input. A display-off input forces every column to one fixed level.

Top module: `lcd_seg_driver`

## Requirements
- R1: While reset is held low, and after it is released before any load, the line register is all zeros, and the enable output is low. With ac_m and disp_off low, every column therefore reads code 2'b01.
- R2: With dir_rev low and bus_wide high, the k-th accepted chunk (k counted from 0) writes data bit i into line bit 8k+i. Column j (0-based) uses output bits lvl_out[2j+1:2j].
- R3: With dir_rev high, a chunk that would land on line bit p in forward order lands on line bit 159-p instead. chain_b is then the enable input and chain_a the enable output. With dir_rev low, chain_a is the input and chain_b the output.
- R4: With bus_wide low, each chunk carries only data bits 3:0, and bits 7:4 are ignored. Two chunks fill one group, the first chunk filling the group's lower four positions.
- R5: A clock edge with load high copies the staging register into the line register. The same edge returns the counter to the first group, so the next line starts there, even if the current line was only partly filled.
- R6: The outputs do not change while the staging register is being written. Only a load edge changes the line register.
- R7: A chunk is accepted only if the enable input is high on that edge, or if the driver has already accepted a chunk since the last load. After a single sampled high pulse on the enable input, the driver goes on to take its whole share.
- R8: On the edge that writes the last position of the line, the enable output goes high for exactly one clock. Further shift clocks before the next load are ignored.
- R9: Drive-level codes are V0=2'b00, V2=2'b01, V3=2'b10 and V5=2'b11. A set bit gives V0 when ac_m is low and V5 when ac_m is high. A clear bit gives V2 when ac_m is low and V3 when ac_m is high.
- R10: When disp_off is high, every column reads V5 (2'b11), whatever the latched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 8 | Parallel column data; only bits 3:0 are used in 4-bit mode |
| bus_wide | input | 1 | 1 selects the 8-bit bus, 0 selects the 4-bit bus |
| dir_rev | input | 1 | 0 fills from column 1 upward, 1 fills from the last column downward |
| load | input | 1 | Line-load strobe |
| ac_m | input | 1 | AC-inversion phase |
| disp_off | input | 1 | Forces every column to V5 |
| chain_a | inout | 1 | Enable input when dir_rev=0, enable output when dir_rev=1 |
| chain_b | inout | 1 | Enable output when dir_rev=0, enable input when dir_rev=1 |
| lvl_out | output | 320 | Two-bit drive-level code for each column, column j at bits 2j+1:2j |

## Verification
The assertions watch four things on every cycle. The enable-output pulse never lasts more than one clock. The staging register stays frozen once the line is full, and also while no enable has been seen. The line register changes only on a load edge. Every load returns the counter to the first group and clears the full state. Only the bench's scenarios can show the column mapping, since that needs a known data pattern written in and read back: forward and reverse fill, nibble order, ignored upper nibble, and a restart after a partial line. The same goes for hand-over of the token between chain pins and the four level codes under AC inversion and display-off.

// File: rtl/lcd_seg_driver.sv
module lcd_seg_driver #(
  parameter int COLS = 160,
  parameter int BUSW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUSW-1:0]     din,
  input  logic                bus_wide,
  input  logic                dir_rev,
  input  logic                load,
  input  logic                ac_m,
  input  logic                disp_off,
  inout  wire                 chain_a,
  inout  wire                 chain_b,
  output logic [2*COLS-1:0]   lvl_out
);
  localparam int PW   = $clog2(COLS + BUSW + 1);
  localparam int OW   = $clog2(BUSW);
  localparam int HALF = BUSW / 2;

  logic [COLS-1:0] stage, line_q;
  logic [PW-1:0]   pos, step, pos_end;
  logic            full, active, eo;

  wire en_in = dir_rev ? chain_b : chain_a;
  assign chain_b = dir_rev ? 1'bz : eo;
  assign chain_a = dir_rev ? eo : 1'bz;

  assign step    = bus_wide ? PW'(BUSW) : PW'(HALF);
  assign pos_end = pos + step;

  wire accept = (en_in | active) & ~full & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      full   <= 1'b0;
      active <= 1'b0;
      eo     <= 1'b0;
    end else begin
      eo <= 1'b0;
      if (load) begin
        pos    <= '0;
        full   <= 1'b0;
        active <= 1'b0;
      end else if (accept) begin
        active <= 1'b1;
        if (pos_end >= PW'(COLS)) begin
          pos  <= '0;
          full <= 1'b1;
          eo   <= 1'b1;
        end else begin
          pos <= pos_end;
        end
      end
    end
  end

  for (genvar j = 0; j < COLS; j++) begin : g_col
    logic          s_bit, l_bit;
    logic [PW-1:0] lp, off;
    logic          hit;

    assign lp  = dir_rev ? PW'(COLS - 1 - j) : PW'(j);
    assign off = lp - pos;
    assign hit = accept && (lp >= pos) && (lp < pos_end);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_bit <= 1'b0;
        l_bit <= 1'b0;
      end else begin
        if (hit) s_bit <= din[off[OW-1:0]];
        if (load) l_bit <= s_bit;
      end
    end

    assign stage[j]  = s_bit;
    assign line_q[j] = l_bit;
    assign lvl_out[2*j +: 2] = disp_off ? 2'b11 :
                               l_bit    ? (ac_m ? 2'b11 : 2'b00) :
                                          (ac_m ? 2'b10 : 2'b01);
  end

  assert_eo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eo |=> !eo);

  assert_full_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !load |=> $stable(stage));

  assert_line_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(line_q));

  assert_load_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pos == '0) && !full && !eo);

  assert_no_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_in && !active |=> $stable(stage));
endmodule

// File: tb/lcd_seg_driver_test.sv
module lcd_seg_driver_test;
  localparam int COLS = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] din = '0;
  logic bus_wide = 1'b1, dir_rev = 1'b0, load = 1'b0, ac_m = 1'b0, disp_off = 1'b0;
  logic drv_a_en = 1'b1, drv_a = 1'b0, drv_b_en = 1'b0, drv_b = 1'b0;
  wire chain_a, chain_b;
  logic [2*COLS-1:0] lvl_out;

  assign chain_a = drv_a_en ? drv_a : 1'bz;
  assign chain_b = drv_b_en ? drv_b : 1'bz;

  lcd_seg_driver uut (
    .clk(clk), .rst_n(rst_n), .din(din), .bus_wide(bus_wide), .dir_rev(dir_rev),
    .load(load), .ac_m(ac_m), .disp_off(disp_off),
    .chain_a(chain_a), .chain_b(chain_b), .lvl_out(lvl_out)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, pos_m = 0;
  logic [COLS-1:0] exp_stage = '0, exp_line = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic feed(input logic [7:0] d);
    int w = bus_wide ? 8 : 4;
    for (int i = 0; i < w; i++) begin
      int p = pos_m + i;
      exp_stage[dir_rev ? COLS-1-p : p] = d[i];
    end
    pos_m += w;
    din = d;
    tick();
  endtask

  task automatic do_load();
    load = 1'b1;
    tick();
    load = 1'b0;
    exp_line = exp_stage;
    pos_m = 0;
  endtask

  task automatic chk_line(input string req);
    int bad = 0, first = -1;
    for (int j = 0; j < COLS; j++) begin
      logic [1:0] e = exp_line[j] ? 2'b00 : 2'b01;
      if (lvl_out[2*j +: 2] !== e) begin
        bad++;
        if (first < 0) first = j;
      end
    end
    chk(bad == 0, req, "line mismatch count (first col shown next)", bad, 0);
    if (bad != 0) $display("  first mismatching column %0d", first);
  endtask

  task automatic t_reset();
    exp_line = '0;
    chk_line("R1");
    chk(chain_b === 1'b0, "R1", "enable out after reset", int'(chain_b), 0);
  endtask

  task automatic t_fill8_fwd();
    dir_rev = 0; bus_wide = 1; drv_a_en = 1; drv_a = 1; drv_b_en = 0;
    for (int k = 0; k < 20; k++) begin
      feed(8'(k * 13 + 5));
      if (k == 18) chk(chain_b === 1'b0, "R8", "enable out before last group", int'(chain_b), 0);
      if (k == 19) chk(chain_b === 1'b1, "R8", "enable out after last group", int'(chain_b), 1);
    end
    chk_line("R6");
    din = 8'hFF;
    tick();
    chk(chain_b === 1'b0, "R8", "enable out one clock later", int'(chain_b), 0);
    tick();
    do_load();
    chk_line("R2");
  endtask

  task automatic t_levels();
    ac_m = 1; #1;
    chk(lvl_out[1:0] == 2'b11, "R9", "set bit with ac_m high", int'(lvl_out[1:0]), 3);
    chk(lvl_out[3:2] == 2'b10, "R9", "clear bit with ac_m high", int'(lvl_out[3:2]), 2);
    ac_m = 0; #1;
    chk(lvl_out[1:0] == 2'b00, "R9", "set bit with ac_m low", int'(lvl_out[1:0]), 0);
    chk(lvl_out[3:2] == 2'b01, "R9", "clear bit with ac_m low", int'(lvl_out[3:2]), 1);
    disp_off = 1; #1;
    chk(lvl_out == {2*COLS{1'b1}}, "R10", "display off all V5", int'(lvl_out[3:0]), 15);
    disp_off = 0; #1;
    chk_line("R10");
  endtask

  task automatic t_fill4_rev();
    dir_rev = 1; bus_wide = 0; drv_a_en = 0; drv_b_en = 1; drv_b = 1;
    for (int k = 0; k < 40; k++) begin
      feed({4'b1010, 4'((k * 5 + 1) & 15)});
      if (k == 38) chk(chain_a === 1'b0, "R3", "reverse enable out early", int'(chain_a), 0);
      if (k == 39) chk(chain_a === 1'b1, "R3", "reverse enable out on chain_a", int'(chain_a), 1);
    end
    do_load();
    chk_line("R4");
    chk(lvl_out[2*(COLS-1) +: 2] == (exp_line[COLS-1] ? 2'b00 : 2'b01), "R3",
        "last column holds first bit", int'(lvl_out[2*(COLS-1) +: 2]), exp_line[COLS-1] ? 0 : 1);
  endtask

  task automatic t_enable();
    dir_rev = 0; bus_wide = 1; drv_b_en = 0; drv_a_en = 1; drv_a = 0;
    for (int k = 0; k < 3; k++) begin
      din = 8'hFF;
      tick();
    end
    drv_a = 1;
    feed(8'h3C);
    drv_a = 0;
    for (int k = 1; k < 20; k++) feed(8'(k ^ 8'hA6));
    chk(chain_b === 1'b1, "R7", "full after single enable pulse", int'(chain_b), 1);
    do_load();
    chk_line("R7");
  endtask

  task automatic t_partial_load();
    drv_a = 1;
    for (int k = 0; k < 3; k++) feed(8'hFF);
    do_load();
    for (int k = 0; k < 20; k++) feed(8'(k ^ 8'h5A));
    do_load();
    chk_line("R5");
  endtask

  bit done = 0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      chk(1'b0, "watchdog", "run did not finish", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #35;
    t_reset();
    rst_n = 1;
    tick();
    t_reset();
    t_fill8_fwd();
    t_levels();
    t_fill4_rev();
    t_enable();
    t_partial_load();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule